// File: doc/BRIEF.md
# AC'97 Link Power-Down Detector and Reset Sequencer

This block sits beside the transmit side of an AC'97 link controller. It watches the serial data of each outgoing frame and looks for software writing the power-down command to the codec. When it finds that command, it stops the link. Frame sync stays low and the frame position counter is frozen until software brings the link back.

There are two ways back. A warm reset is the warm-request bit held high for at least one microsecond, measured on the system clock. A cold reset is software clearing the cold-acknowledge bit once it has pulsed the codec's external reset line. While the cold-acknowledge bit is low, the block reports that a cold reset is in progress. When software sets the bit again, the link restarts at the first bit of a new frame.

Everything runs on one system clock. Bit timing enters as a one-cycle strobe, `bit_tick`. On each strobe `tx_sdata` carries the link bit for the current frame position.

Top module: `ac97pd_top`

## Requirements
- R1: After reset, `low_power` and `cold_rst_active` are 0 and the frame position is 0, so `frame_sync` is 1.
- R2: A frame has 256 positions: a 16-bit tag slot at positions 0..15, then 20-bit slots, each sent most significant bit first. The position advances only on a `bit_tick` cycle. `frame_sync` is 1 exactly at positions 0..15 while the link is running and `warm_req` is 0.
- R3: `low_power` rises on the edge that samples position 55 when all of the following hold in the same frame:
  - tag positions 0, 1 and 2 were all 1;
  - the command address slot (positions 16..35) had slot bit 19 = 0 (write) and slot bits 18:12 = 7'h26;
  - the command data slot (positions 36..55) had slot bit 16 = 1. This is data bit 12, at position 39.
- R4: If any one of the R3 conditions is missing, `low_power` stays 0.
- R5: While `low_power` is 1, `frame_sync` is 0 and `bit_tick` strobes are ignored. `low_power` stays 1 until a reset exit.
- R6: While in low power, `warm_req` held high on 250 consecutive clock edges (1 µs at the default 250 MHz) clears `low_power` on the 250th edge. A shorter pulse changes nothing.
- R7: While `warm_req` is 1, `frame_sync` is 0.
- R8: When `cold_ack_n` is 0 at a clock edge, `cold_rst_active` is 1 after that edge and `low_power` is 0. While `cold_ack_n` is 0, `frame_sync` is 0 and strobes are ignored. When `cold_ack_n` returns to 1, `cold_rst_active` clears and the frame restarts at position 0.
- R9: If the edge that completes a warm reset is also the edge that detects the power-down command, the link stays running and `low_power` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking a link bit |
| tx_sdata | input | 1 | Outgoing serial link bit, valid with `bit_tick` |
| warm_req | input | 1 | Warm-reset control bit from software |
| cold_ack_n | input | 1 | Cold-reset control bit; 0 = cold reset under way |
| frame_sync | output | 1 | Frame sync line to the codec |
| low_power | output | 1 | Link held in power-down |
| cold_rst_active | output | 1 | Cold reset in progress |

## Verification
Two functions can fall on the same clock edge: the edge that finishes a warm reset and the edge that samples the last bit of a power-down command.

The bench provokes this on purpose. It sends the first 55 bits of a valid power-down frame, raises `warm_req`, and idles for 249 edges. It then delivers bit 55 on the 250th edge with `warm_req` still high. The result is judged by `low_power` staying 0 afterwards. The vector table supplies the contrast: the same frame without the warm pulse does set `low_power`.

// File: rtl/ac97pd_pkg.sv
package ac97pd_pkg;

   typedef enum logic [1:0] {
      LS_RUN    = 2'd0,
      LS_LOWPWR = 2'd1,
      LS_COLD   = 2'd2
   } link_state_e;

   localparam int unsigned HZ_PER_MHZ = 1000000;

   function automatic int unsigned cycles_per_us(input int unsigned hz);
      return hz / HZ_PER_MHZ;
   endfunction

endpackage

// File: rtl/ac97pd_framer.sv
module ac97pd_framer #(
   parameter int FRAME_BITS = 256,
   parameter int TAG_BITS   = 16,
   parameter int PW         = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          bit_tick,
   input  logic          warm_req,
   output logic [PW-1:0] bit_pos,
   output logic          frame_sync
);
   localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);
   localparam logic [PW-1:0] TAG_END  = PW'(TAG_BITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bit_pos <= '0;
      else if (!run)
         bit_pos <= '0;
      else if (bit_tick)
         bit_pos <= (bit_pos == LAST_POS) ? '0 : bit_pos + 1'b1;
   end

   assign frame_sync = run && !warm_req && (bit_pos < TAG_END);

endmodule

// File: rtl/ac97pd_slot_dec.sv
module ac97pd_slot_dec #(
   parameter int         TAG_BITS    = 16,
   parameter int         SLOT_BITS   = 20,
   parameter int         PW          = 8,
   parameter int         TAG_CHK     = 3,
   parameter logic [6:0] PD_REG_ADDR = 7'h26,
   parameter int         PD_DATA_BIT = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic [PW-1:0] bit_pos,
   input  logic          sdata,
   output logic          pd_detect
);
   localparam int ADDR_HI  = SLOT_BITS - 2;
   localparam int ADDR_LO  = SLOT_BITS - 8;
   localparam int DATA_IDX = PD_DATA_BIT + (SLOT_BITS - 16);
   localparam logic [PW-1:0] S1_LAST = PW'(TAG_BITS + SLOT_BITS - 1);
   localparam logic [PW-1:0] S2_LAST = PW'(TAG_BITS + 2 * SLOT_BITS - 1);
   localparam logic [PW-1:0] TAG_LIM = PW'(TAG_CHK);

   logic [SLOT_BITS-2:0] hist;
   logic [SLOT_BITS-1:0] slot_nx;
   logic                 tag_ok, addr_ok;

   assign slot_nx = {hist, sdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist    <= '0;
         tag_ok  <= 1'b0;
         addr_ok <= 1'b0;
      end else if (bit_en) begin
         hist <= slot_nx[SLOT_BITS-2:0];
         if (bit_pos == '0)
            tag_ok <= sdata;
         else if (bit_pos < TAG_LIM)
            tag_ok <= tag_ok & sdata;
         if (bit_pos == S1_LAST)
            addr_ok <= !slot_nx[SLOT_BITS-1] &&
                       (slot_nx[ADDR_HI:ADDR_LO] == PD_REG_ADDR);
      end
   end

   assign pd_detect = bit_en && (bit_pos == S2_LAST) && tag_ok && addr_ok &&
                      slot_nx[DATA_IDX];

endmodule

// File: rtl/ac97pd_warm_timer.sv
module ac97pd_warm_timer #(
   parameter int CYCLES = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic warm_req,
   output logic warm_done
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] TERM = CW'(CYCLES);
   localparam logic [CW-1:0] PRE  = CW'(CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!warm_req)
         cnt <= '0;
      else if (cnt != TERM)
         cnt <= cnt + 1'b1;
   end

   assign warm_done = warm_req && (cnt == PRE);

endmodule

// File: rtl/ac97pd_link_ctrl.sv
module ac97pd_link_ctrl
   import ac97pd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pd_detect,
   input  logic warm_done,
   input  logic cold_ack_n,
   output logic run,
   output logic low_power,
   output logic cold_rst_active
);
   link_state_e st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         LS_RUN: begin
            if (!cold_ack_n)
               st_nx = LS_COLD;
            else if (pd_detect && !warm_done)
               st_nx = LS_LOWPWR;
         end
         LS_LOWPWR: begin
            if (!cold_ack_n)
               st_nx = LS_COLD;
            else if (warm_done)
               st_nx = LS_RUN;
         end
         LS_COLD: begin
            if (cold_ack_n)
               st_nx = LS_RUN;
         end
         default: st_nx = LS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= LS_RUN;
      else
         st <= st_nx;
   end

   assign run             = (st == LS_RUN);
   assign low_power       = (st == LS_LOWPWR);
   assign cold_rst_active = (st == LS_COLD);

endmodule

// File: rtl/ac97pd_top.sv
module ac97pd_top
   import ac97pd_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ = 250000000,
   parameter int          FRAME_BITS  = 256,
   parameter int          TAG_BITS    = 16,
   parameter int          SLOT_BITS   = 20,
   parameter int          TAG_CHK     = 3,
   parameter logic [6:0]  PD_REG_ADDR = 7'h26,
   parameter int          PD_DATA_BIT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic tx_sdata,
   input  logic warm_req,
   input  logic cold_ack_n,
   output logic frame_sync,
   output logic low_power,
   output logic cold_rst_active
);
   localparam int PW       = $clog2(FRAME_BITS);
   localparam int WARM_CYC = int'(cycles_per_us(CLK_FREQ_HZ));

   if (CLK_FREQ_HZ < HZ_PER_MHZ) begin : g_bad_clk
      $error("ac97pd_top: CLK_FREQ_HZ must be at least 1 MHz");
   end
   if (FRAME_BITS < TAG_BITS + 2 * SLOT_BITS) begin : g_bad_frame
      $error("ac97pd_top: frame too short for tag and two command slots");
   end
   if (SLOT_BITS < 16 || PD_DATA_BIT > 15) begin : g_bad_slot
      $error("ac97pd_top: slot must hold a 16-bit data word");
   end
   if (TAG_CHK < 1 || TAG_CHK > TAG_BITS) begin : g_bad_tag
      $error("ac97pd_top: TAG_CHK out of range");
   end

   logic          run, pd_detect, warm_done;
   logic [PW-1:0] bit_pos;

   ac97pd_framer #(
      .FRAME_BITS (FRAME_BITS),
      .TAG_BITS   (TAG_BITS),
      .PW         (PW)
   ) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .bit_tick   (bit_tick),
      .warm_req   (warm_req),
      .bit_pos    (bit_pos),
      .frame_sync (frame_sync)
   );

   ac97pd_slot_dec #(
      .TAG_BITS    (TAG_BITS),
      .SLOT_BITS   (SLOT_BITS),
      .PW          (PW),
      .TAG_CHK     (TAG_CHK),
      .PD_REG_ADDR (PD_REG_ADDR),
      .PD_DATA_BIT (PD_DATA_BIT)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_tick && run),
      .bit_pos   (bit_pos),
      .sdata     (tx_sdata),
      .pd_detect (pd_detect)
   );

   ac97pd_warm_timer #(
      .CYCLES (WARM_CYC)
   ) u_warm (
      .clk       (clk),
      .rst_n     (rst_n),
      .warm_req  (warm_req),
      .warm_done (warm_done)
   );

   ac97pd_link_ctrl u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .pd_detect       (pd_detect),
      .warm_done       (warm_done),
      .cold_ack_n      (cold_ack_n),
      .run             (run),
      .low_power       (low_power),
      .cold_rst_active (cold_rst_active)
   );

endmodule

// File: rtl/ac97pd_chk.sv
module ac97pd_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic warm_req,
   input logic cold_ack_n,
   input logic frame_sync,
   input logic low_power,
   input logic cold_rst_active
);

   // R5: a powered-down link emits no frame sync
   assert_sync_quiet_lowpwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      low_power |-> !frame_sync);

   // R5: power-down persists without a reset request
   assert_lowpwr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && cold_ack_n && !warm_req) |=> low_power);

   // R7: warm request forces sync inactive
   assert_sync_quiet_warm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      warm_req |-> !frame_sync);

   // R8: cold reset request is reported on the next cycle
   assert_cold_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cold_ack_n |=> (cold_rst_active && !low_power));

   // R8: low power and cold reset never coexist
   assert_state_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(low_power && cold_rst_active));

   // R3: entry into low power only on a bit strobe with no cold reset
   assert_lowpwr_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_power) |-> ($past(bit_tick) && $past(cold_ack_n)));

   // R6: leaving low power needs a reset request
   assert_lowpwr_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(low_power) |-> ($past(warm_req) || !$past(cold_ack_n)));

endmodule

bind ac97pd_top ac97pd_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .bit_tick        (bit_tick),
   .warm_req        (warm_req),
   .cold_ack_n      (cold_ack_n),
   .frame_sync      (frame_sync),
   .low_power       (low_power),
   .cold_rst_active (cold_rst_active)
);

// File: tb/ac97pd_top_tb.sv
module ac97pd_top_tb;
   localparam int unsigned CLK_HZ = 250000000;
   localparam int WN = CLK_HZ / 1000000;
   localparam int NV = 10;
   // {expect, read_flag, tag[2:0], addr[6:0], data[15:0]}
   localparam logic [27:0] VEC [NV] = '{
      {1'b0, 1'b0, 3'b011, 7'h26, 16'h1000},
      {1'b1, 1'b0, 3'b111, 7'h26, 16'h1000},
      {1'b0, 1'b0, 3'b110, 7'h26, 16'h1000},
      {1'b0, 1'b0, 3'b101, 7'h26, 16'hFFFF},
      {1'b0, 1'b0, 3'b111, 7'h27, 16'h1000},
      {1'b0, 1'b0, 3'b111, 7'h66, 16'h1000},
      {1'b0, 1'b0, 3'b111, 7'h26, 16'hEFFF},
      {1'b0, 1'b1, 3'b111, 7'h26, 16'h1000},
      {1'b1, 1'b0, 3'b111, 7'h26, 16'hFFFF},
      {1'b1, 1'b0, 3'b111, 7'h26, 16'h1234}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic bit_tick = 1'b0, tx_sdata = 1'b0, warm_req = 1'b0, cold_ack_n = 1'b1;
   logic frame_sync, low_power, cold_rst_active;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   ac97pd_top #(.CLK_FREQ_HZ(CLK_HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_sdata(tx_sdata),
      .warm_req(warm_req), .cold_ack_n(cold_ack_n), .frame_sync(frame_sync),
      .low_power(low_power), .cold_rst_active(cold_rst_active));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [255:0] mk(input logic rd, input logic [2:0] tag,
                                       input logic [6:0] addr, input logic [15:0] dat);
      logic [255:0] f;
      f = {128{2'b10}};
      f[255:240] = {tag, 13'h1FFF};
      f[239:220] = {rd, addr, 12'h000};
      f[219:200] = {dat, 4'h0};
      return f;
   endfunction

   task automatic send_bit(input logic b);
      tx_sdata = b;
      bit_tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bit_tick = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send_frame(input logic [255:0] f, input bit chk_sync);
      for (int p = 0; p < 256; p++) begin
         if (chk_sync && (p == 0 || p == 15 || p == 16 || p == 255))
            chk("R2 sync position", frame_sync, (p < 16) ? 1 : 0);
         send_bit(f[255 - p]);
      end
   endtask

   task automatic cold_exit();
      cold_ack_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R8 cold active", cold_rst_active, 1);
      chk("R8 low_power cleared", low_power, 0);
      chk("R8 sync low", frame_sync, 0);
      for (int k = 0; k < 3; k++) send_bit(1'b1);
      cold_ack_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R8 cold released", cold_rst_active, 0);
      chk("R8 restart at position 0", frame_sync, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog R1: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [255:0] fr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 low_power", low_power, 0);
      chk("R1 cold_rst_active", cold_rst_active, 0);
      chk("R1 frame_sync", frame_sync, 1);

      for (int i = 0; i < NV; i++) begin
         fr = mk(VEC[i][26], VEC[i][25:23], VEC[i][22:16], VEC[i][15:0]);
         send_frame(fr, i == 0);
         chk(VEC[i][27] ? "R3 detect" : "R4 no detect", low_power, VEC[i][27]);
         if (low_power) begin
            chk("R5 sync low in low power", frame_sync, 0);
            cold_exit();
         end
      end

      // low power persists through ignored frames, then warm exits
      send_frame(mk(1'b0, 3'b111, 7'h26, 16'h1000), 1'b0);
      chk("R3 detect before warm test", low_power, 1);
      send_frame({256{1'b1}}, 1'b0);
      chk("R5 ticks ignored", low_power, 1);
      chk("R5 sync stays low", frame_sync, 0);
      warm_req = 1'b1;
      repeat (WN - 1) @(posedge clk);
      @(negedge clk);
      warm_req = 1'b0;
      chk("R6 short warm ignored", low_power, 1);
      @(negedge clk);
      warm_req = 1'b1;
      repeat (WN) @(posedge clk);
      @(negedge clk);
      chk("R6 warm exit", low_power, 0);
      chk("R7 sync low during warm", frame_sync, 0);
      warm_req = 1'b0;
      #1;
      chk("R7 sync back after warm", frame_sync, 1);

      // collision: warm completion on the detecting edge
      @(negedge clk);
      fr = mk(1'b0, 3'b111, 7'h26, 16'h1000);
      for (int p = 0; p < 55; p++) send_bit(fr[255 - p]);
      warm_req = 1'b1;
      repeat (WN - 1) @(posedge clk);
      @(negedge clk);
      tx_sdata = fr[255 - 55];
      bit_tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bit_tick = 1'b0;
      warm_req = 1'b0;
      chk("R9 warm wins over detect", low_power, 0);
      for (int p = 56; p < 256; p++) send_bit(fr[255 - p]);
      chk("R9 frame realigned", frame_sync, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule